// File: doc/BRIEF.md
# Hierarchical Two-Level Lookahead Adder

This block is a purely combinational binary adder. It takes two operands and a carry-in and returns their sum and carry-out. It is not built as a chain of carries. Each bit first forms a generate term (both operand bits set) and a propagate term (either operand bit set). Groups of four bits fold those terms into a group generate and a group propagate. A shared four-input lookahead carry unit then turns the four group terms and the incoming carry into the carry into each group, together with the carry out of the whole set. Each 4-bit slice uses those carries to form its sum bits. The carry-out that a slice could produce for itself is never used to feed the next slice.

The same carry unit appears at every level of the tree. At the bit level it serves inside a slice. At the slice level it combines four slices into a 16-bit block. At the block level it combines four 16-bit blocks into a 64-bit adder. The parameter `WIDTH` selects 16 or 64. The top also exports the propagate and generate terms of its widest level, so that a further lookahead level can be placed above it without reaching into the adder.

Top module: `lookahead_adder`

## Requirements
- R1: `sum` equals the low `WIDTH` bits of `a + b + cin`, with the operands taken as unsigned numbers.
- R2: `cout` equals bit `WIDTH` of the unsigned total `a + b + cin`.
- R3: The carry into each 4-bit slice, and into each 16-bit block when `WIDTH` is 64, equals the carry out of the unsigned sum of all operand bits below that group plus `cin`. For example, with `WIDTH` 16, a = 0x0FFF, b = 0x0001 and cin = 0 give sum 0x1000.
- R4: `grp_p` is 1 exactly when every bit position has at least one operand bit set, that is when `a | b` is all ones.
- R5: `grp_g` is 1 exactly when `a + b` with no carry-in produces a carry out of bit `WIDTH-1`. It follows that `cout` always equals `grp_g | (grp_p & cin)`.
- R6: `WIDTH` may be 16 or 64. With 64, four 16-bit blocks are joined by the same lookahead carry unit that is used inside each block.
- R7: With all operand bits set in `a`: adding b = 1 and cin = 0 gives sum 0 and cout 1, and adding b = 0 and cin = 1 also gives sum 0 and cout 1.
- R8: With a = 0, b = 0 and cin = 0, every output (`sum`, `cout`, `grp_p`, `grp_g`) is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| cout | output | 1 | Carry out of bit WIDTH-1 |
| grp_p | output | 1 | Propagate term of the whole adder, for a higher lookahead level |
| grp_g | output | 1 | Generate term of the whole adder, for a higher lookahead level |

## Verification
The embedded checks compare the results with arithmetic built from the operands. They assume that `a`, `b` and `cin` are all driven to known values, and each check is skipped while any of these inputs is unknown. The bench drives every input from time zero and changes inputs only at falling clock edges. It compares the outputs after the inputs have settled and before the next edge. The stimulus mixes random operands with directed patterns chosen to stress the lookahead paths: all-ones plus one, all-ones plus carry-in, zero plus zero, alternating bit patterns that propagate through every group, and carries that cross slice and block boundaries.

// File: rtl/cla_pkg.sv
package cla_pkg;

    localparam int unsigned LANES = 4;
    localparam int unsigned SLICE_BITS = 4;
    localparam int unsigned BLOCK_BITS = LANES * SLICE_BITS;

    // Four lanes of propagate/generate terms feeding one carry unit
    typedef struct packed {
        logic [LANES-1:0] p;
        logic [LANES-1:0] g;
    } lane_pg_t;

    // Folded propagate/generate of one group
    typedef struct packed {
        logic p;
        logic g;
    } grp_pg_t;

    // Per-bit terms: generate when both bits set, propagate when either set
    function automatic lane_pg_t bit_terms(input logic [LANES-1:0] x,
                                           input logic [LANES-1:0] y);
        lane_pg_t t;
        t.p = x | y;
        t.g = x & y;
        return t;
    endfunction

    // Gather four group terms into one lane bundle
    function automatic lane_pg_t gather(input grp_pg_t g0, input grp_pg_t g1,
                                        input grp_pg_t g2, input grp_pg_t g3);
        lane_pg_t t;
        t.p = {g3.p, g2.p, g1.p, g0.p};
        t.g = {g3.g, g2.g, g1.g, g0.g};
        return t;
    endfunction

endpackage

// File: rtl/cla_carry_unit.sv
module cla_carry_unit
    import cla_pkg::*;
(
    input  lane_pg_t          lanes,
    input  logic              cin,
    output logic [LANES:0]    carry,
    output grp_pg_t           grp
);

    logic [LANES-1:0] p;
    logic [LANES-1:0] g;

    assign p = lanes.p;
    assign g = lanes.g;

    // Two-level sum-of-products carries, no chaining between lanes
    assign carry[0] = cin;
    assign carry[1] = g[0] | (p[0] & cin);
    assign carry[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin);
    assign carry[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
                    | (p[2] & p[1] & p[0] & cin);
    assign carry[4] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                    | (p[3] & p[2] & p[1] & g[0])
                    | (p[3] & p[2] & p[1] & p[0] & cin);

    assign grp.p = &p;
    assign grp.g = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                 | (p[3] & p[2] & p[1] & g[0]);

    // R5: the factored group form must agree with the expanded top carry
    always_comb begin
        if (!$isunknown({lanes, cin})) begin
            p_group_fold_r5: assert (carry[LANES] == (grp.g | (grp.p & cin)))
                else $error("carry unit group fold mismatch");
        end
    end

endmodule

// File: rtl/cla_slice4.sv
module cla_slice4
    import cla_pkg::*;
(
    input  logic [SLICE_BITS-1:0] a,
    input  logic [SLICE_BITS-1:0] b,
    input  logic                  cin,
    output logic [SLICE_BITS-1:0] sum,
    output grp_pg_t               grp
);

    lane_pg_t            bits;
    logic [SLICE_BITS:0] c;
    logic [SLICE_BITS:0] ref_total;

    assign bits = bit_terms(a, b);

    cla_carry_unit u_bit_lac (
        .lanes (bits),
        .cin   (cin),
        .carry (c),
        .grp   (grp)
    );

    assign sum = a ^ b ^ c[SLICE_BITS-1:0];
    assign ref_total = {1'b0, a} + {1'b0, b} + {{SLICE_BITS{1'b0}}, cin};

    // R1 / R2 at slice scale; the slice carry-out is only observed here
    always_comb begin
        if (!$isunknown({a, b, cin})) begin
            p_slice_sum_r1: assert (sum == ref_total[SLICE_BITS-1:0])
                else $error("slice sum mismatch");
            p_slice_cout_r2: assert (c[SLICE_BITS] == ref_total[SLICE_BITS])
                else $error("slice carry-out mismatch");
        end
    end

endmodule

// File: rtl/cla_block16.sv
module cla_block16
    import cla_pkg::*;
(
    input  logic [BLOCK_BITS-1:0] a,
    input  logic [BLOCK_BITS-1:0] b,
    input  logic                  cin,
    output logic [BLOCK_BITS-1:0] sum,
    output logic                  cout,
    output grp_pg_t               grp
);

    grp_pg_t        slice_grp [LANES];
    lane_pg_t       lane_terms;
    logic [LANES:0] slice_cin;

    for (genvar k = 0; k < LANES; k++) begin : g_slice
        cla_slice4 u_slice (
            .a   (a[k*SLICE_BITS +: SLICE_BITS]),
            .b   (b[k*SLICE_BITS +: SLICE_BITS]),
            .cin (slice_cin[k]),
            .sum (sum[k*SLICE_BITS +: SLICE_BITS]),
            .grp (slice_grp[k])
        );
    end

    assign lane_terms = gather(slice_grp[0], slice_grp[1], slice_grp[2], slice_grp[3]);

    cla_carry_unit u_slice_lac (
        .lanes (lane_terms),
        .cin   (cin),
        .carry (slice_cin),
        .grp   (grp)
    );

    assign cout = slice_cin[LANES];

    // R3: each slice carry-in matches arithmetic over the bits below it
    for (genvar k = 1; k < LANES; k++) begin : g_chk_cin
        localparam int unsigned LOW = k * SLICE_BITS;
        logic [LOW:0] low_total;
        assign low_total = {1'b0, a[LOW-1:0]} + {1'b0, b[LOW-1:0]} + {{LOW{1'b0}}, cin};
        always_comb begin
            if (!$isunknown({a, b, cin})) begin
                p_slice_carry_r3: assert (slice_cin[k] == low_total[LOW])
                    else $error("slice carry-in mismatch at lane %0d", k);
            end
        end
    end

endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             grp_p,
    output logic             grp_g
);

    localparam int unsigned BLOCKS = WIDTH / BLOCK_BITS;

    initial begin
        p_width_r6: assert (WIDTH == BLOCK_BITS || WIDTH == BLOCK_BITS * LANES)
            else $error("WIDTH must be 16 or 64");
    end

    if (BLOCKS == 1) begin : g_w16
        grp_pg_t top_grp;

        cla_block16 u_block (
            .a    (a),
            .b    (b),
            .cin  (cin),
            .sum  (sum),
            .cout (cout),
            .grp  (top_grp)
        );

        assign grp_p = top_grp.p;
        assign grp_g = top_grp.g;
    end else begin : g_w64
        grp_pg_t        blk_grp [LANES];
        logic [LANES-1:0] blk_cout;
        lane_pg_t       blk_terms;
        logic [LANES:0] blk_cin;
        grp_pg_t        top_grp;

        for (genvar k = 0; k < LANES; k++) begin : g_block
            cla_block16 u_block (
                .a    (a[k*BLOCK_BITS +: BLOCK_BITS]),
                .b    (b[k*BLOCK_BITS +: BLOCK_BITS]),
                .cin  (blk_cin[k]),
                .sum  (sum[k*BLOCK_BITS +: BLOCK_BITS]),
                .cout (blk_cout[k]),
                .grp  (blk_grp[k])
            );
        end

        assign blk_terms = gather(blk_grp[0], blk_grp[1], blk_grp[2], blk_grp[3]);

        // R6: the same carry unit, one level up
        cla_carry_unit u_block_lac (
            .lanes (blk_terms),
            .cin   (cin),
            .carry (blk_cin),
            .grp   (top_grp)
        );

        assign cout  = blk_cin[LANES];
        assign grp_p = top_grp.p;
        assign grp_g = top_grp.g;

        // R3: the block's own carry-out agrees with the lookahead carry above it
        always_comb begin
            if (!$isunknown({a, b, cin})) begin
                for (int k = 0; k < LANES; k++) begin
                    p_block_carry_r3: assert (blk_cout[k] == blk_cin[k+1])
                        else $error("block carry mismatch at %0d", k);
                end
            end
        end
    end

    logic [WIDTH:0] total;
    assign total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

    always_comb begin
        if (!$isunknown({a, b, cin})) begin
            p_sum_r1: assert (sum == total[WIDTH-1:0])
                else $error("sum mismatch");
            p_cout_r2: assert (cout == total[WIDTH])
                else $error("carry-out mismatch");
            p_prop_r4: assert (grp_p == &(a | b))
                else $error("group propagate mismatch");
            p_gen_r5: assert (cout == (grp_g | (grp_p & cin)))
                else $error("group generate inconsistent with carry-out");
        end
    end

endmodule

// File: tb/lookahead_adder_tb.sv
module lookahead_adder_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [63:0] a64, b64;
    logic        cin;
    logic [15:0] sum16;
    logic [63:0] sum64;
    logic        cout16, cout64, gp16, gg16, gp64, gg64;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    lookahead_adder #(.WIDTH(16)) u_dut (
        .a (a64[15:0]), .b (b64[15:0]), .cin (cin),
        .sum (sum16), .cout (cout16), .grp_p (gp16), .grp_g (gg16)
    );

    lookahead_adder #(.WIDTH(64)) u_dut64 (
        .a (a64), .b (b64), .cin (cin),
        .sum (sum64), .cout (cout64), .grp_p (gp64), .grp_g (gg64)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: plain unsigned arithmetic
    task automatic apply(input string tag, input logic [63:0] x, input logic [63:0] y,
                         input logic c);
        logic [16:0] t16, g16;
        logic [64:0] t64, g64;
        @(negedge clk);
        a64 = x; b64 = y; cin = c;
        #2;
        t16 = {1'b0, x[15:0]} + {1'b0, y[15:0]} + {16'd0, c};
        g16 = {1'b0, x[15:0]} + {1'b0, y[15:0]};
        t64 = {1'b0, x} + {1'b0, y} + {64'd0, c};
        g64 = {1'b0, x} + {1'b0, y};
        check({tag, " R1 sum16"},  {48'd0, sum16}, {48'd0, t16[15:0]});
        check({tag, " R2 cout16"}, {63'd0, cout16}, {63'd0, t16[16]});
        check({tag, " R4 prop16"}, {63'd0, gp16}, {63'd0, &(x[15:0] | y[15:0])});
        check({tag, " R5 gen16"},  {63'd0, gg16}, {63'd0, g16[16]});
        check({tag, " R6 R1 sum64"},  sum64, t64[63:0]);
        check({tag, " R6 R2 cout64"}, {63'd0, cout64}, {63'd0, t64[64]});
        check({tag, " R6 R4 prop64"}, {63'd0, gp64}, {63'd0, &(x | y)});
        check({tag, " R6 R5 gen64"},  {63'd0, gg64}, {63'd0, g64[64]});
    endtask

    initial begin
        a64 = '0; b64 = '0; cin = 1'b0;
        repeat (2) @(posedge clk);
        // R8: idle state, all zero in
        apply("R8 zero", 64'd0, 64'd0, 1'b0);
        check("R8 sum16 idle", {48'd0, sum16}, 64'd0);
        check("R8 flags idle", {60'd0, cout16, gp16, gg16, cout64}, 64'd0);
        // R7 corners
        apply("R7 ones+1", '1, 64'd1, 1'b0);
        check("R7 sum64 wraps", sum64, 64'd0);
        check("R7 cout64 set", {63'd0, cout64}, 64'd1);
        apply("R7 ones+cin", '1, 64'd0, 1'b1);
        check("R7 cin sum16", {48'd0, sum16}, 64'd0);
        check("R7 cin cout16", {63'd0, cout16}, 64'd1);
        // R3 carries across slice and block boundaries
        apply("R3 slice", 64'h0FFF, 64'h0001, 1'b0);
        check("R3 crosses slices", {48'd0, sum16}, 64'h1000);
        apply("R3 nibble", 64'h000F, 64'h0000, 1'b1);
        apply("R3 block", 64'h0000_FFFF_FFFF_FFFF, 64'h0, 1'b1);
        check("R3 crosses blocks", sum64, 64'h0001_0000_0000_0000);
        // Alternating patterns: full propagate chains
        apply("R4 alt cin1", 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1);
        apply("R4 alt cin0", 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0);
        apply("R5 gen top", 64'h8000_0000_0000_8000, 64'h8000_0000_0000_8000, 1'b0);
        apply("R1 alt same", 64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555, 1'b1);
        // Random operands
        for (int i = 0; i < 400; i++) begin
            apply("R1 rand", {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule